// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This block decides when a small processor core must leave its current instruction stream and jump to a fixed service address. Six interrupt sources feed it one-cycle event strobes: a USB event, overflow of timer 0, overflow of timer 1, valid play data, completion of an 8-bit serial transfer in either direction, and the 8 kHz record timeout. Each strobe is latched into a pending flag. The flag is serviced when its per-source enable and the global enable are both set and the hardware call stack still has room. A seventh entry, reset, sends execution to address zero once the synchronized reset is released.

When a source is taken, the unit raises a vector strobe with the 12-bit service address and a one-cycle push request. The push request lets the call stack save the return address. In the same cycle it closes the global enable and drops the serviced pending flag. Service addresses sit four words apart from 0x004 upward. When several requests are eligible, the source with the lowest address wins. Software reopens the global enable on return, and it can discard pending flags through a clear input.

Top module: `irq_vector_dispatch`

## Requirements
- R1: While reset is asserted, take, push, vec_addr, gie and pending are all zero.
- R2: On the third rising clock edge after rst_n rises, take is high for exactly one cycle, with vec_addr = 0x000 and push low. Before that edge take stays low.
- R3: A high bit on src_evt sets the matching pending bit at the next edge. The bit stays set while its enable is low, until it is serviced or cleared by sw_clr.
- R4: take with push rises one edge after a cycle in which gie is 1, stack_full is 0 and (pending & src_en) is nonzero. In no other cycle does it rise.
- R5: Source index i (0 USB, 1 timer 0, 2 timer 1, 3 play, 4 serial, 5 record) has vector 0x004 + 4*i. Among the eligible sources, the lowest index is taken.
- R6: When an interrupt is taken, push is high in that cycle only, gie drops to 0, and only the serviced pending bit is cleared.
- R7: While stack_full is high, no interrupt is taken, and pending and gie keep their values. A held request is taken one edge after stack_full falls.
- R8: A new event on the source being serviced, arriving in the same cycle, leaves its pending bit set.
- R9: gie_set raises gie at the next edge and gie_clr lowers it. Taking an interrupt overrides gie_set.
- R10: A bit of sw_clr clears its pending bit at the next edge, unless an event for that source arrives in the same cycle, in which case the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_evt | input | 6 | One-cycle event strobe per source |
| src_en | input | 6 | Per-source interrupt enable |
| gie_set | input | 1 | Opens the global interrupt enable |
| gie_clr | input | 1 | Closes the global interrupt enable |
| sw_clr | input | 6 | Software discard of pending flags |
| stack_full | input | 1 | Call stack has no free entry |
| take | output | 1 | Vector-taken strobe |
| push | output | 1 | Request to save the return address |
| vec_addr | output | 12 | Target address while take is high |
| gie | output | 1 | Current global enable |
| pending | output | 6 | Latched request flags |

## Verification
Every nonzero pending pattern is combined with every enable mask. The bench computes the winning index as the lowest set bit of their intersection. This separates priority order, address arithmetic and the rule that masked flags survive. Held requests under a full stack show that refusal stalls dispatch without losing state. Collisions of an event with servicing, and of an event with a software clear, tell apart the two orders in which set and clear could be resolved. The boot vector is distinguished from a normal dispatch by its zero address and its missing push.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  localparam int IVD_NSRC     = 6;
  localparam int IVD_ADDR_W   = 12;
  localparam int IVD_VEC_BASE = 4;
  localparam int IVD_VEC_STEP = 4;

  typedef enum int {
    SRC_USB    = 0,
    SRC_TMR0   = 1,
    SRC_TMR1   = 2,
    SRC_PLAY   = 3,
    SRC_SERIAL = 4,
    SRC_RECORD = 5
  } ivd_src_e;

  function automatic int vec_of(input int idx, input int base, input int step);
    return base + idx * step;
  endfunction
endpackage

// File: rtl/ivd_rst_sync.sv
module ivd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/ivd_req_latch.sv
module ivd_req_latch #(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] upd;

  always_comb begin
    upd    = set_i | clr_i;
    pend_d = (pend_q & ~clr_i) | set_i;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q[g] <= 1'b0;
      else if (upd[g]) pend_q[g] <= pend_d[g];
    end

    // R3
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && !clr_i[g]) |=> pend_q[g]);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> pend_q[g]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ivd_pick.sv
module ivd_pick #(
  parameter int NSRC  = 6,
  parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  req_i,
  output logic [NSRC-1:0]  grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
    any_o = |req_i;
  end

  // R5
  always_comb begin
    grant_onehot_chk: assert ($onehot0(grant_o));
    grant_subset_chk: assert ((grant_o & ~req_i) == '0);
  end
endmodule

// File: rtl/irq_vector_dispatch.sv
module irq_vector_dispatch
  import ivd_pkg::*;
#(
  parameter int NSRC     = IVD_NSRC,
  parameter int ADDR_W   = IVD_ADDR_W,
  parameter int VEC_BASE = IVD_VEC_BASE,
  parameter int VEC_STEP = IVD_VEC_STEP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_evt,
  input  logic [NSRC-1:0]   src_en,
  input  logic              gie_set,
  input  logic              gie_clr,
  input  logic [NSRC-1:0]   sw_clr,
  input  logic              stack_full,
  output logic              take,
  output logic              push,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              gie,
  output logic [NSRC-1:0]   pending
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic              rst_i;
  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   eligible;
  logic [NSRC-1:0]   grant;
  logic [IDX_W-1:0]  win_idx;
  logic              any_elig;
  logic              fire;
  logic [NSRC-1:0]   clr_all;

  logic              boot_q, boot_d;
  logic              gie_q, gie_d;
  logic              take_q, take_d;
  logic              push_q, push_d;
  logic [ADDR_W-1:0] vec_q, vec_d;

  ivd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  ivd_req_latch #(.NSRC(NSRC)) u_latch (
    .clk    (clk),
    .rst_n  (rst_i),
    .set_i  (src_evt),
    .clr_i  (clr_all),
    .pend_o (pend)
  );

  ivd_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
    .req_i   (eligible),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (any_elig)
  );

  always_comb begin
    eligible = pend & src_en;
    fire     = !boot_q && gie_q && any_elig && !stack_full;
    clr_all  = sw_clr | (fire ? grant : '0);

    boot_d = 1'b0;
    take_d = boot_q || fire;
    push_d = fire;
    vec_d  = vec_q;
    if (boot_q)
      vec_d = '0;
    else if (fire)
      vec_d = ADDR_W'(vec_of(int'(win_idx), VEC_BASE, VEC_STEP));

    gie_d = gie_q;
    if (fire)         gie_d = 1'b0;
    else if (gie_clr) gie_d = 1'b0;
    else if (gie_set) gie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      boot_q <= 1'b1;
      gie_q  <= 1'b0;
      take_q <= 1'b0;
      push_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      boot_q <= boot_d;
      gie_q  <= gie_d;
      take_q <= take_d;
      push_q <= push_d;
      if (take_d) vec_q <= vec_d;
    end
  end

  assign take     = take_q;
  assign push     = push_q;
  assign vec_addr = vec_q;
  assign gie      = gie_q;
  assign pending  = pend;

  // R6
  push_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_i)
    push_q |-> take_q);

  // R4
  take_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (take_q && push_q) |-> $past(gie_q && !stack_full));

  // R6
  gie_closed_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (take_q && push_q) |-> !gie_q);

  // R6
  push_single_chk: assert property (@(posedge clk) disable iff (!rst_i)
    push_q |=> !push_q);

  // R2
  boot_zero_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (take_q && !push_q) |-> (vec_q == '0));

  // R7
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_i)
    stack_full |=> !push_q);
endmodule

// File: tb/irq_vector_dispatch_tb.sv
module irq_vector_dispatch_tb;
  localparam int N = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_evt = '0;
  logic [N-1:0]  src_en = '0;
  logic          gie_set = 1'b0;
  logic          gie_clr = 1'b0;
  logic [N-1:0]  sw_clr = '0;
  logic          stack_full = 1'b0;
  logic          take, push, gie;
  logic [11:0]   vec_addr;
  logic [N-1:0]  pending;

  int errs = 0;
  int checks = 0;

  irq_vector_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_en(src_en),
    .gie_set(gie_set), .gie_clr(gie_clr), .sw_clr(sw_clr),
    .stack_full(stack_full), .take(take), .push(push),
    .vec_addr(vec_addr), .gie(gie), .pending(pending)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cleanup();
    sw_clr = '1; gie_clr = 1'b1; src_en = '0; stack_full = 1'b0;
    step();
    sw_clr = '0; gie_clr = 1'b0;
    chk("R10 cleanup pending", int'(pending), 0);
    chk("R9 cleanup gie", int'(gie), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 take", int'(take), 0);
    chk("R1 push", int'(push), 0);
    chk("R1 vec", int'(vec_addr), 0);
    chk("R1 gie", int'(gie), 0);
    chk("R1 pending", int'(pending), 0);

    rst_n = 1'b1;
    step(); step();
    chk("R2 no early boot", int'(take), 0);
    step();
    chk("R2 boot take", int'(take), 1);
    chk("R2 boot vec", int'(vec_addr), 0);
    chk("R2 boot push", int'(push), 0);
    step();
    chk("R2 boot once", int'(take), 0);

    // Sweep every pending pattern against every enable mask
    for (int p = 1; p < 64; p++) begin
      for (int e = 0; e < 64; e++) begin
        int m;
        int lo;
        src_evt = N'(p); src_en = N'(e);
        step();
        src_evt = '0;
        chk("R3 latch", int'(pending), p);
        gie_set = 1'b1;
        step();
        gie_set = 1'b0;
        chk("R9 gie set", int'(gie), 1);
        chk("R4 no take before gie", int'(take), 0);
        step();
        m = p & e;
        if (m != 0) begin
          lo = 0;
          while (((m >> lo) & 1) == 0) lo++;
          chk("R4 take", int'(take), 1);
          chk("R5 vector", int'(vec_addr), 4 + 4 * lo);
          chk("R6 push", int'(push), 1);
          chk("R6 gie cleared", int'(gie), 0);
          chk("R6 serviced bit", int'(pending), p & ~(1 << lo));
        end else begin
          chk("R4 no take", int'(take), 0);
          chk("R3 masked held", int'(pending), p);
        end
        cleanup();
        chk("R6 one-cycle take", int'(take), 0);
      end
    end

    // R7 stack full holds requests
    src_evt = 6'b101000; src_en = '1; stack_full = 1'b1;
    step();
    src_evt = '0; gie_set = 1'b1;
    step();
    gie_set = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R7 no take while full", int'(take), 0);
      chk("R7 pending kept", int'(pending), 6'b101000);
      chk("R7 gie kept", int'(gie), 1);
    end
    stack_full = 1'b0;
    step();
    chk("R7 take after room", int'(take), 1);
    chk("R5 play vector", int'(vec_addr), 12'h010);
    chk("R6 leaves record", int'(pending), 6'b100000);
    gie_set = 1'b1;
    step();
    gie_set = 1'b0;
    step();
    chk("R5 record vector", int'(vec_addr), 12'h018);
    chk("R4 record take", int'(take), 1);
    cleanup();

    // R8 event collides with service
    src_evt = 6'b000001; src_en = '1;
    step();
    src_evt = '0; gie_set = 1'b1;
    step();
    gie_set = 1'b0; src_evt = 6'b000001;
    step();
    src_evt = '0;
    chk("R8 take", int'(take), 1);
    chk("R8 usb vector", int'(vec_addr), 12'h004);
    chk("R8 bit kept", int'(pending), 1);
    cleanup();

    // R9 take overrides gie_set, gie_clr closes
    src_evt = 6'b000010; src_en = '1;
    step();
    src_evt = '0; gie_set = 1'b1;
    step();
    step();
    chk("R9 take beats set", int'(gie), 0);
    chk("R9 take happened", int'(take), 1);
    gie_set = 1'b0;
    cleanup();
    gie_set = 1'b1;
    step();
    gie_set = 1'b0; gie_clr = 1'b1;
    step();
    gie_clr = 1'b0;
    chk("R9 gie clr", int'(gie), 0);

    // R10 software clear and collision
    src_evt = 6'b000100; src_en = '0;
    step();
    sw_clr = 6'b000100;
    step();
    src_evt = '0;
    chk("R10 event beats clear", int'(pending), 6'b000100);
    step();
    sw_clr = '0;
    chk("R10 clear", int'(pending), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule